// File: doc/BRIEF.md
# Legacy Screen Write Remapper

This block sits on the expansion-bus side of a video card that carries 256 KB of video RAM. It decodes each bus access in the cycle it is offered and produces a registered video-RAM request one clock later: an address, a select, a write enable and byte-lane strobes. Accesses to the direct window at bus addresses 0xC0000 to 0xFFFFF reach video RAM at the matching offset, for reads and for writes. Writes aimed at the old 32 KB screen at 0x20000 to 0x27FFF are copied into the top-left corner of the larger bitmap. Each old row of 128 bytes lands at the start of a 256-byte row in video RAM.

The remap runs in one direction only. Old-screen reads never reach video RAM. The second old screen at 0x28000 is never touched. The remap is active only in the two modes that share the old pixel layout. When another expansion card asserts its claim on the top 16 KB of the window, video RAM stays silent there, so the other card can answer instead. A driver can find the card by writing a key long word through the old screen and reading it back at the base of the window.

Top module: `scrwin_remap`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `vram_sel`, `vram_we`, `vram_addr` and `vram_be` are all zero.
- R2: A valid access to 0xC0000..0xFFFFF, outside the claimed range, gives the following outputs one clock later:
  - `vram_sel` = 1;
  - `vram_addr` = `bus_addr` - 0xC0000;
  - `vram_we` equal to `bus_wr`.
- R3: A valid access to any address outside both the direct window and the old first screen leaves `vram_sel` low one clock later.
- R4: A valid write to 0x20000..0x27FFF in mode 0 (two/four colour) or mode 1 (eight colour) gives the following outputs one clock later:
  - `vram_sel` = 1 and `vram_we` = 1;
  - `vram_addr` = (offset / 128) * 256 + (offset % 128), where offset = `bus_addr` - 0x20000.
- R5: A write to 0x20000..0x27FFF in mode 2 (sixteen colour) or mode 3 (256 colour) is ignored: `vram_sel` stays low and video RAM contents are unchanged.
- R6: A read of 0x20000..0x27FFF never selects video RAM, in any mode.
- R7: No access to the second old screen at 0x28000..0x2FFFF selects video RAM, in any mode.
- R8: While `ext_claim` is high, no access to 0xFC000..0xFFFFF selects video RAM. While it is low, that range behaves as the rest of the window.
- R9: `vram_be` carries `bus_be` of the selected access unchanged, bit i for byte lane i. It is zero whenever `vram_sel` is low.
- R10: In mode 0 or 1, a long-word write of a key to 0x20000 followed by a long-word read of 0xC0000 returns that key.
- R11: The outputs respond exactly one clock after the access. A cycle with `bus_valid` low produces no selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe for the current cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 20 | Expansion-bus byte address |
| bus_be | input | 4 | Byte-lane strobes of the access |
| disp_mode | input | 2 | Display mode: 0 two/four colour, 1 eight colour, 2 sixteen colour, 3 256 colour |
| ext_claim | input | 1 | Another card owns 0xFC000..0xFFFFF |
| vram_sel | output | 1 | Video RAM selected (registered) |
| vram_we | output | 1 | Video RAM write enable (registered) |
| vram_addr | output | 18 | Video RAM byte address (registered) |
| vram_be | output | 4 | Video RAM byte-lane strobes (registered) |

## Verification
A wrong decode shows on `vram_sel` in the very next cycle. Depending on the fault, the remapper either selects video RAM on a yielded, second-screen or old-screen read access, or stays silent on a window access. A fault in the row arithmetic shows only as a wrong `vram_addr` for old-screen writes past the first 128 bytes. It therefore takes a write to a row above zero, or to the last byte of the area, to show it. Such a fault also corrupts the presence key only if the key write lands away from offset zero. A lost byte-lane strobe or a stale mode input shows as a mismatched read-back through the bench's RAM model a few accesses later.

// File: rtl/scrwin_pkg.sv
package scrwin_pkg;

  typedef enum logic [1:0] {
    MODE_MONO4  = 2'd0,
    MODE_COL8   = 2'd1,
    MODE_COL16  = 2'd2,
    MODE_COL256 = 2'd3
  } disp_mode_e;

  // Modes whose pixel layout matches the old screen, so remapping is legal
  function automatic logic mode_allows_remap(input logic [1:0] m);
    return (m == MODE_MONO4) || (m == MODE_COL8);
  endfunction

endpackage

// File: rtl/scrwin_direct_dec.sv
module scrwin_direct_dec #(
  parameter int ADDR_W   = 20,
  parameter int VRAM_AW  = 18,
  parameter int CLAIM_AW = 14,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hC0000
) (
  input  logic               bus_valid,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               ext_claim,
  output logic               hit,
  output logic [VRAM_AW-1:0] vaddr
);
  localparam int TAG_W = ADDR_W - VRAM_AW;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:VRAM_AW];

  logic in_win;
  logic in_top;

  assign in_win = (bus_addr[ADDR_W-1:VRAM_AW] == WIN_TAG);

  generate
    if (CLAIM_AW < VRAM_AW) begin : g_claim
      assign in_top = &bus_addr[VRAM_AW-1:CLAIM_AW];
    end else begin : g_noclaim
      assign in_top = 1'b0;
    end
  endgenerate

  assign hit   = bus_valid && in_win && !(ext_claim && in_top);
  assign vaddr = bus_addr[VRAM_AW-1:0];

endmodule

// File: rtl/scrwin_legacy_map.sv
module scrwin_legacy_map
  import scrwin_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int VRAM_AW = 18,
  parameter int LEG_AW  = 15,
  parameter int SRC_RW  = 7,
  parameter int DST_RW  = 8,
  parameter logic [ADDR_W-1:0] LEG_BASE = 20'h20000
) (
  input  logic               bus_valid,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [1:0]         disp_mode,
  output logic               hit,
  output logic [VRAM_AW-1:0] vaddr
);
  localparam int ROW_W = LEG_AW - SRC_RW;
  localparam int TAG_W = ADDR_W - LEG_AW;
  localparam logic [TAG_W-1:0] LEG_TAG = LEG_BASE[ADDR_W-1:LEG_AW];

  logic [ROW_W-1:0]  row;
  logic [SRC_RW-1:0] col;
  logic              in_leg;

  assign in_leg = (bus_addr[ADDR_W-1:LEG_AW] == LEG_TAG);
  assign row    = bus_addr[LEG_AW-1:SRC_RW];
  assign col    = bus_addr[SRC_RW-1:0];

  assign hit   = bus_valid && bus_wr && in_leg && mode_allows_remap(disp_mode);
  assign vaddr = (VRAM_AW'(row) << DST_RW) | VRAM_AW'(col);

endmodule

// File: rtl/scrwin_out_reg.sv
module scrwin_out_reg #(
  parameter int VRAM_AW = 18,
  parameter int BE_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_d,
  input  logic               we_d,
  input  logic [VRAM_AW-1:0] addr_d,
  input  logic [BE_W-1:0]    be_d,
  output logic               sel_q,
  output logic               we_q,
  output logic [VRAM_AW-1:0] addr_q,
  output logic [BE_W-1:0]    be_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      be_q   <= '0;
    end else begin
      sel_q  <= sel_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      be_q   <= be_d;
    end
  end
endmodule

// File: rtl/scrwin_remap.sv
module scrwin_remap #(
  parameter int ADDR_W   = 20,
  parameter int VRAM_AW  = 18,
  parameter int BE_W     = 4,
  parameter int CLAIM_AW = 14,
  parameter int LEG_AW   = 15,
  parameter int SRC_RW   = 7,
  parameter int DST_RW   = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hC0000,
  parameter logic [ADDR_W-1:0] LEG_BASE = 20'h20000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_valid,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BE_W-1:0]    bus_be,
  input  logic [1:0]         disp_mode,
  input  logic               ext_claim,
  output logic               vram_sel,
  output logic               vram_we,
  output logic [VRAM_AW-1:0] vram_addr,
  output logic [BE_W-1:0]    vram_be
);
  logic               dir_hit, leg_hit;
  logic [VRAM_AW-1:0] dir_addr, leg_addr;
  logic               sel_d, we_d;
  logic [VRAM_AW-1:0] addr_d;
  logic [BE_W-1:0]    be_d;

  scrwin_direct_dec #(
    .ADDR_W(ADDR_W), .VRAM_AW(VRAM_AW), .CLAIM_AW(CLAIM_AW), .WIN_BASE(WIN_BASE)
  ) u_dir (
    .bus_valid(bus_valid), .bus_addr(bus_addr), .ext_claim(ext_claim),
    .hit(dir_hit), .vaddr(dir_addr)
  );

  scrwin_legacy_map #(
    .ADDR_W(ADDR_W), .VRAM_AW(VRAM_AW), .LEG_AW(LEG_AW),
    .SRC_RW(SRC_RW), .DST_RW(DST_RW), .LEG_BASE(LEG_BASE)
  ) u_leg (
    .bus_valid(bus_valid), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .disp_mode(disp_mode), .hit(leg_hit), .vaddr(leg_addr)
  );

  // Direct window wins; the two ranges never overlap at default parameters
  always_comb begin
    sel_d  = dir_hit || leg_hit;
    we_d   = 1'b0;
    addr_d = '0;
    be_d   = '0;
    if (dir_hit) begin
      we_d   = bus_wr;
      addr_d = dir_addr;
      be_d   = bus_be;
    end else if (leg_hit) begin
      we_d   = 1'b1;
      addr_d = leg_addr;
      be_d   = bus_be;
    end
  end

  scrwin_out_reg #(.VRAM_AW(VRAM_AW), .BE_W(BE_W)) u_out (
    .clk(clk), .rst(rst),
    .sel_d(sel_d), .we_d(we_d), .addr_d(addr_d), .be_d(be_d),
    .sel_q(vram_sel), .we_q(vram_we), .addr_q(vram_addr), .be_q(vram_be)
  );

endmodule

// File: rtl/scrwin_remap_chk.sv
module scrwin_remap_chk #(
  parameter int ADDR_W   = 20,
  parameter int VRAM_AW  = 18,
  parameter int BE_W     = 4,
  parameter int CLAIM_AW = 14,
  parameter int LEG_AW   = 15,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hC0000,
  parameter logic [ADDR_W-1:0] LEG_BASE = 20'h20000
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_valid,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [BE_W-1:0]    bus_be,
  input logic [1:0]         disp_mode,
  input logic               ext_claim,
  input logic               vram_sel,
  input logic               vram_we,
  input logic [VRAM_AW-1:0] vram_addr,
  input logic [BE_W-1:0]    vram_be
);
  localparam logic [ADDR_W-VRAM_AW-1:0] WTAG = WIN_BASE[ADDR_W-1:VRAM_AW];
  localparam logic [ADDR_W-LEG_AW-1:0]  LTAG = LEG_BASE[ADDR_W-1:LEG_AW];
  localparam logic [ADDR_W-LEG_AW-1:0]  STAG = LTAG + 1'b1;

  logic in_win, in_top, in_leg, in_scr1;
  assign in_win  = bus_addr[ADDR_W-1:VRAM_AW] == WTAG;
  assign in_top  = &bus_addr[VRAM_AW-1:CLAIM_AW];
  assign in_leg  = bus_addr[ADDR_W-1:LEG_AW] == LTAG;
  assign in_scr1 = bus_addr[ADDR_W-1:LEG_AW] == STAG;

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!vram_sel && !vram_we && vram_be == '0));

  // R2
  window_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && in_win && !(ext_claim && in_top)) |=>
      (vram_sel && vram_addr == $past(bus_addr[VRAM_AW-1:0]) && vram_we == $past(bus_wr)));

  // R5
  mode_block_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && in_leg && disp_mode[1]) |=> !vram_sel);

  // R6
  legacy_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_wr && in_leg) |=> !vram_sel);

  // R7
  second_screen_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && in_scr1) |=> !vram_sel);

  // R8
  claim_yield_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && in_win && in_top && ext_claim) |=> !vram_sel);

  // R9
  lane_pass_chk: assert property (@(posedge clk) disable iff (rst)
    vram_sel |-> (vram_be == $past(bus_be)));

  // R9
  lane_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !vram_sel |-> (vram_be == '0 && !vram_we));

  // R11
  idle_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !vram_sel);

endmodule

bind scrwin_remap scrwin_remap_chk #(
  .ADDR_W(ADDR_W), .VRAM_AW(VRAM_AW), .BE_W(BE_W), .CLAIM_AW(CLAIM_AW),
  .LEG_AW(LEG_AW), .WIN_BASE(WIN_BASE), .LEG_BASE(LEG_BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_be(bus_be), .disp_mode(disp_mode),
  .ext_claim(ext_claim), .vram_sel(vram_sel), .vram_we(vram_we),
  .vram_addr(vram_addr), .vram_be(vram_be)
);

// File: tb/sim_scrwin_remap.sv
`timescale 1ns/1ps
module sim_scrwin_remap;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_wr = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [1:0]  disp_mode = '0;
  logic        ext_claim = 1'b0;
  logic        vram_sel, vram_we;
  logic [17:0] vram_addr;
  logic [3:0]  vram_be;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [7:0] ram [int];

  always #2.5 clk = ~clk;

  scrwin_remap u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .disp_mode(disp_mode),
    .ext_claim(ext_claim), .vram_sel(vram_sel), .vram_we(vram_we),
    .vram_addr(vram_addr), .vram_be(vram_be)
  );

  typedef struct packed {
    logic        v;
    logic        w;
    logic [1:0]  m;
    logic        c;
    logic [19:0] a;
    logic [3:0]  be;
    logic        es;
    logic        ew;
    logic [17:0] ea;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 2'd0, 1'b0, 20'hC0000, 4'hF, 1'b1, 1'b0, 18'h00000, 4'd2},  // R2 read base
    '{1'b1, 1'b1, 2'd3, 1'b0, 20'hD2345, 4'h3, 1'b1, 1'b1, 18'h12345, 4'd2},  // R2 write, R9 lanes
    '{1'b1, 1'b1, 2'd2, 1'b0, 20'hFFFFF, 4'h8, 1'b1, 1'b1, 18'h3FFFF, 4'd8},  // R8 unclaimed top
    '{1'b1, 1'b1, 2'd0, 1'b1, 20'hFC000, 4'hF, 1'b0, 1'b0, 18'h00000, 4'd8},  // R8 claimed
    '{1'b1, 1'b0, 2'd1, 1'b1, 20'hFBFFF, 4'h1, 1'b1, 1'b0, 18'h3BFFF, 4'd8},  // R8 below claim
    '{1'b1, 1'b1, 2'd0, 1'b0, 20'h20000, 4'hF, 1'b1, 1'b1, 18'h00000, 4'd4},  // R4 origin
    '{1'b1, 1'b1, 2'd1, 1'b0, 20'h2007F, 4'h1, 1'b1, 1'b1, 18'h0007F, 4'd4},  // R4 row end
    '{1'b1, 1'b1, 2'd0, 1'b0, 20'h20080, 4'h2, 1'b1, 1'b1, 18'h00100, 4'd4},  // R4 second row
    '{1'b1, 1'b1, 2'd1, 1'b0, 20'h27FFF, 4'h4, 1'b1, 1'b1, 18'h0FF7F, 4'd4},  // R4 last byte
    '{1'b1, 1'b1, 2'd0, 1'b0, 20'h21234, 4'hC, 1'b1, 1'b1, 18'h02434, 4'd4},  // R4 mid
    '{1'b1, 1'b1, 2'd2, 1'b0, 20'h20100, 4'hF, 1'b0, 1'b0, 18'h00000, 4'd5},  // R5 mode 2
    '{1'b1, 1'b1, 2'd3, 1'b0, 20'h20100, 4'hF, 1'b0, 1'b0, 18'h00000, 4'd5},  // R5 mode 3
    '{1'b1, 1'b0, 2'd0, 1'b0, 20'h20100, 4'hF, 1'b0, 1'b0, 18'h00000, 4'd6},  // R6 read
    '{1'b1, 1'b1, 2'd0, 1'b0, 20'h28000, 4'hF, 1'b0, 1'b0, 18'h00000, 4'd7},  // R7 start
    '{1'b1, 1'b1, 2'd1, 1'b0, 20'h2FFFF, 4'hF, 1'b0, 1'b0, 18'h00000, 4'd7},  // R7 end
    '{1'b1, 1'b1, 2'd0, 1'b0, 20'h1FFFF, 4'hF, 1'b0, 1'b0, 18'h00000, 4'd3},  // R3 below
    '{1'b1, 1'b0, 2'd0, 1'b0, 20'hBFFFF, 4'hF, 1'b0, 1'b0, 18'h00000, 4'd3},  // R3 below window
    '{1'b0, 1'b1, 2'd0, 1'b0, 20'hC1000, 4'hF, 1'b0, 1'b0, 18'h00000, 4'd11}  // R11 idle
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access; drives at negedge, samples one clock later, updates RAM model
  task automatic access(input logic w, input logic [1:0] m, input logic c,
                        input logic [19:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    bus_valid = 1'b1; bus_wr = w; disp_mode = m; ext_claim = c;
    bus_addr = a; bus_be = be;
    @(posedge clk); #1;
    rd = '0;
    if (vram_sel) begin
      for (int i = 0; i < 4; i++) begin
        if (vram_we && vram_be[i]) ram[int'(vram_addr) + i] = wd[8*i +: 8];
        if (ram.exists(int'(vram_addr) + i)) rd[8*i +: 8] = ram[int'(vram_addr) + i];
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    // R1: activity during reset must not leak to outputs
    @(negedge clk);
    bus_valid = 1'b1; bus_wr = 1'b1; bus_addr = 20'hC0010; bus_be = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    check(!vram_sel && !vram_we && vram_addr == '0 && vram_be == '0, "R1 in reset",
          {vram_sel, vram_we, vram_addr, vram_be}, 64'h0);
    @(negedge clk);
    bus_valid = 1'b0; rst = 1'b0;
    @(posedge clk); #1;
    check(!vram_sel && vram_be == '0, "R1 after release",
          {vram_sel, vram_we, vram_addr, vram_be}, 64'h0);

    // Vector table, back to back accesses (R11 latency)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_valid = VEC[i].v; bus_wr = VEC[i].w; disp_mode = VEC[i].m;
      ext_claim = VEC[i].c; bus_addr = VEC[i].a; bus_be = VEC[i].be;
      @(posedge clk); #1;
      begin
        logic [3:0] ebe;
        ebe = VEC[i].es ? VEC[i].be : 4'h0;
        check(vram_sel == VEC[i].es && vram_we == VEC[i].ew &&
              vram_addr == VEC[i].ea && vram_be == ebe,
              $sformatf("R%0d vector %0d (R9 lanes)", VEC[i].rq, i),
              {vram_sel, vram_we, vram_addr, vram_be},
              {VEC[i].es, VEC[i].ew, VEC[i].ea, ebe});
      end
    end

    // R10: presence test, mode 0 then mode 1
    access(1'b1, 2'd0, 1'b0, 20'hC0000, 4'hF, 32'h0, rd);
    access(1'b1, 2'd0, 1'b0, 20'h20000, 4'hF, 32'hA5C30F96, rd);
    access(1'b0, 2'd0, 1'b0, 20'hC0000, 4'hF, 32'h0, rd);
    check(rd == 32'hA5C30F96, "R10 presence mode 0", rd, 32'hA5C30F96);
    access(1'b1, 2'd1, 1'b0, 20'hC0000, 4'hF, 32'h0, rd);
    access(1'b1, 2'd1, 1'b0, 20'h20000, 4'hF, 32'h5A3CF069, rd);
    access(1'b0, 2'd1, 1'b0, 20'hC0000, 4'hF, 32'h0, rd);
    check(rd == 32'h5A3CF069, "R10 presence mode 1", rd, 32'h5A3CF069);

    // R5: key write in mode 3 leaves video RAM unchanged
    access(1'b1, 2'd3, 1'b0, 20'hC0000, 4'hF, 32'h0, rd);
    access(1'b1, 2'd3, 1'b0, 20'h20000, 4'hF, 32'h11223344, rd);
    access(1'b0, 2'd3, 1'b0, 20'hC0000, 4'hF, 32'h0, rd);
    check(rd == 32'h0, "R5 no remap in mode 3", rd, 32'h0);

    // R7: second screen write leaves video RAM unchanged
    access(1'b1, 2'd0, 1'b0, 20'h28000, 4'hF, 32'hDEADBEEF, rd);
    access(1'b0, 2'd0, 1'b0, 20'hC0000, 4'hF, 32'h0, rd);
    check(rd == 32'h0, "R7 second screen untouched", rd, 32'h0);

    // R9: single lane write changes only lane 2
    access(1'b1, 2'd0, 1'b0, 20'hC0000, 4'h4, 32'h77665544, rd);
    access(1'b0, 2'd0, 1'b0, 20'hC0000, 4'hF, 32'h0, rd);
    check(rd == 32'h00660000, "R9 lane 2 only", rd, 32'h00660000);

    // R8: claimed top yields, releasing claim restores access
    access(1'b1, 2'd0, 1'b1, 20'hFC000, 4'hF, 32'hCAFEF00D, rd);
    access(1'b0, 2'd0, 1'b0, 20'hFC000, 4'hF, 32'h0, rd);
    check(rd == 32'h0 && vram_sel, "R8 claimed write dropped", {vram_sel, rd}, {1'b1, 32'h0});

    @(negedge clk);
    bus_valid = 1'b0;
    @(posedge clk); #1;
    check(!vram_sel, "R11 idle after traffic", vram_sel, 0);
    finish_run();
  end

endmodule